// File: doc/BRIEF.md
# FIFO Threshold and Flow-Control Monitor

This block follows the fill levels of a receive FIFO and a transmit FIFO. It does not store the data. It counts push and pop strobes from each side and compares the counts against thresholds that the host programs. From these comparisons it drives three outputs:

- a level-sensitive receive-data-available interrupt;
- a transmit-space interrupt;
- a flow-control request that asks the remote sender to stop, and later lets it resume.

The host uses a small register port to do three things:

- choose between a legacy coded-trigger mode and an enhanced mode with fully arbitrary trigger levels;
- program the interrupt triggers and the hysteresis thresholds for flow control;
- read back both fill counters and a flow-state word.

A single enable bit switches between the two trigger schemes. When enhanced mode is on, the coded trigger field is ignored. Flow control always uses the programmed low and high thresholds, which are separate from the interrupt triggers.

Top module: `fifo_level_monitor`

## Requirements
- R1: After reset the following hold. Both fill counts are 0. The config register (address 0) is 0x00, the receive trigger (1) is 1, the transmit trigger (2) is 0, the flow low level (3) is 32 and the flow high level (4) is 96. rx_irq is 0, tx_irq is 1 and flow_stop is 0.
- R2: Each fill counter behaves as follows. An increment strobe alone adds 1 and stops at 128. A decrement strobe alone subtracts 1 and stops at 0. Both strobes together, or neither, leave the count unchanged. The new count is visible one cycle after the strobe.
- R3: A read at address 5 returns the receive fill count and a read at address 6 returns the transmit fill count. Read data is combinational from reg_addr.
- R4: In enhanced mode (config bit 0 = 1), rx_irq is 1 exactly when the receive fill is greater than or equal to the receive trigger register.
- R5: In enhanced mode, tx_irq is 1 exactly when the transmit fill is less than or equal to the transmit trigger register.
- R6: In legacy mode (config bit 0 = 0), the trigger registers are ignored and the triggers come from the config register. The receive trigger is selected by config bits 7:6, where codes 0,1,2,3 give 1,4,8,14. The transmit trigger is selected by config bits 5:4, where codes 0,1,2,3 give 0,4,8,16.
- R7: In enhanced mode, config bits 7:4 have no effect on either interrupt.
- R8: flow_stop rises in the cycle after the receive fill is at or above the high level. It falls in the cycle after the fill is at or below the low level. Between the two levels it holds its value. If both conditions are true at once, stop wins.
- R9: A read at address 7 returns a flow-state word. Bit 0 shows peer_stop, which means the local transmitter is held off by the remote side. Bit 1 shows flow_stop. The other bits are 0.
- R10: A write at address 0 to 4 takes effect on the next clock and reads back unchanged. A write at address 5, 6 or 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| rx_inc | input | 1 | Receive FIFO push strobe |
| rx_dec | input | 1 | Receive FIFO pop strobe |
| tx_inc | input | 1 | Transmit FIFO push strobe |
| tx_dec | input | 1 | Transmit FIFO pop strobe |
| peer_stop | input | 1 | Remote side asks the local transmitter to pause |
| rx_irq | output | 1 | Receive data available interrupt |
| tx_irq | output | 1 | Transmit space interrupt |
| flow_stop | output | 1 | Request to the remote sender to stop |

## Verification
The counters are exercised by four kinds of stimulus:

- long single-direction runs that reach the ceiling and the floor, which separate saturation from wraparound;
- simultaneous push and pop, which shows whether the two strobes cancel;
- sweeps through all four legacy codes with the trigger registers set far away, which show which trigger source is in effect;
- enhanced mode with junk in the legacy field.

The receive level is then ramped slowly through the flow window, both upward and downward. This separates the hysteresis hold from a plain comparator and shows the one-cycle lag of flow_stop. Writes to the read-only addresses are followed by reads of every register.

// File: rtl/flm_pkg.sv
`timescale 1ns/1ps
package flm_pkg;

   typedef enum logic [2:0] {
      A_CFG     = 3'd0,
      A_RX_TRIG = 3'd1,
      A_TX_TRIG = 3'd2,
      A_FLOW_LO = 3'd3,
      A_FLOW_HI = 3'd4,
      A_RX_FILL = 3'd5,
      A_TX_FILL = 3'd6,
      A_FSTAT   = 3'd7
   } flm_addr_e;

   localparam int unsigned CFG_ENH_BIT = 0;

   // legacy receive trigger code to level
   function automatic logic [7:0] legacy_rx_level(input logic [1:0] code);
      logic [7:0] lvl;
      case (code)
         2'd0:    lvl = 8'd1;
         2'd1:    lvl = 8'd4;
         2'd2:    lvl = 8'd8;
         default: lvl = 8'd14;
      endcase
      return lvl;
   endfunction

   // legacy transmit trigger code to level
   function automatic logic [7:0] legacy_tx_level(input logic [1:0] code);
      logic [7:0] lvl;
      case (code)
         2'd0:    lvl = 8'd0;
         2'd1:    lvl = 8'd4;
         2'd2:    lvl = 8'd8;
         default: lvl = 8'd16;
      endcase
      return lvl;
   endfunction

endpackage

// File: rtl/flm_fill_counter.sv
`timescale 1ns/1ps
module flm_fill_counter #(
   parameter int unsigned DEPTH = 128,
   parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [CW-1:0] level
);

   localparam logic [CW-1:0] TOP = CW'(DEPTH);

   logic [CW-1:0] level_q;
   logic [CW-1:0] level_d;
   logic          at_top;
   logic          at_bottom;

   assign at_top    = (level_q == TOP);
   assign at_bottom = (level_q == '0);

   always_comb begin
      level_d = level_q;
      unique case ({inc, dec})
         2'b10:   if (!at_top)    level_d = level_q + CW'(1);
         2'b01:   if (!at_bottom) level_d = level_q - CW'(1);
         default: level_d = level_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= '0;
      else        level_q <= level_d;
   end

   assign level = level_q;

endmodule

// File: rtl/flm_regs.sv
`timescale 1ns/1ps
module flm_regs
   import flm_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter logic [DW-1:0] RST_RX_TRIG = DW'(1),
   parameter logic [DW-1:0] RST_TX_TRIG = DW'(0),
   parameter logic [DW-1:0] RST_LO      = DW'(32),
   parameter logic [DW-1:0] RST_HI      = DW'(96)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [2:0]    addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] cfg_q,
   output logic [DW-1:0] rx_trig_q,
   output logic [DW-1:0] tx_trig_q,
   output logic [DW-1:0] flow_lo_q,
   output logic [DW-1:0] flow_hi_q
);

   localparam int unsigned NREG = 5;

   logic [DW-1:0] rst_val [NREG];
   logic [DW-1:0] reg_q   [NREG];

   assign rst_val[0] = '0;
   assign rst_val[1] = RST_RX_TRIG;
   assign rst_val[2] = RST_TX_TRIG;
   assign rst_val[3] = RST_LO;
   assign rst_val[4] = RST_HI;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic hit;
      assign hit = wr && (addr == 3'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   reg_q[i] <= rst_val[i];
         else if (hit) reg_q[i] <= wdata;
      end
   end

   assign cfg_q     = reg_q[A_CFG];
   assign rx_trig_q = reg_q[A_RX_TRIG];
   assign tx_trig_q = reg_q[A_TX_TRIG];
   assign flow_lo_q = reg_q[A_FLOW_LO];
   assign flow_hi_q = reg_q[A_FLOW_HI];

endmodule

// File: rtl/flm_trigger_sel.sv
`timescale 1ns/1ps
module flm_trigger_sel
   import flm_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          enh,
   input  logic [1:0]    rx_code,
   input  logic [1:0]    tx_code,
   input  logic [DW-1:0] prog_rx,
   input  logic [DW-1:0] prog_tx,
   output logic [DW-1:0] rx_lvl,
   output logic [DW-1:0] tx_lvl
);

   logic [DW-1:0] leg_rx;
   logic [DW-1:0] leg_tx;

   assign leg_rx = DW'(legacy_rx_level(rx_code));
   assign leg_tx = DW'(legacy_tx_level(tx_code));

   assign rx_lvl = enh ? prog_rx : leg_rx;
   assign tx_lvl = enh ? prog_tx : leg_tx;

endmodule

// File: rtl/flm_flow_ctl.sv
`timescale 1ns/1ps
module flm_flow_ctl #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] fill,
   input  logic [DW-1:0] lo,
   input  logic [DW-1:0] hi,
   output logic          stop
);

   logic stop_q;
   logic set_c;
   logic clr_c;

   assign set_c = (fill >= hi);
   assign clr_c = (fill <= lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stop_q <= 1'b0;
      else if (set_c) stop_q <= 1'b1;
      else if (clr_c) stop_q <= 1'b0;
   end

   assign stop = stop_q;

endmodule

// File: rtl/fifo_level_monitor.sv
`timescale 1ns/1ps
module fifo_level_monitor
   import flm_pkg::*;
#(
   parameter int unsigned DEPTH = 128,
   parameter int unsigned DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [2:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          rx_inc,
   input  logic          rx_dec,
   input  logic          tx_inc,
   input  logic          tx_dec,
   input  logic          peer_stop,
   output logic          rx_irq,
   output logic          tx_irq,
   output logic          flow_stop
);

   localparam int unsigned CW   = $clog2(DEPTH + 1);
   localparam int unsigned NDIR = 2;

   if (DEPTH < 16) begin : g_bad_depth
      $error("fifo_level_monitor: DEPTH must reach the largest legacy level");
   end
   if (CW > DW) begin : g_bad_width
      $error("fifo_level_monitor: fill count does not fit the register width");
   end

   logic [CW-1:0] fill_v [NDIR];
   logic          inc_v  [NDIR];
   logic          dec_v  [NDIR];

   assign inc_v[0] = rx_inc;
   assign dec_v[0] = rx_dec;
   assign inc_v[1] = tx_inc;
   assign dec_v[1] = tx_dec;

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      flm_fill_counter #(.DEPTH(DEPTH), .CW(CW)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (inc_v[d]),
         .dec   (dec_v[d]),
         .level (fill_v[d])
      );
   end

   logic [CW-1:0] rx_fill;
   logic [CW-1:0] tx_fill;
   logic [DW-1:0] rx_fill_w;
   logic [DW-1:0] tx_fill_w;

   assign rx_fill   = fill_v[0];
   assign tx_fill   = fill_v[1];
   assign rx_fill_w = DW'(rx_fill);
   assign tx_fill_w = DW'(tx_fill);

   logic [DW-1:0] cfg_q, rx_trig_q, tx_trig_q, flow_lo_q, flow_hi_q;

   flm_regs #(.DW(DW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .cfg_q     (cfg_q),
      .rx_trig_q (rx_trig_q),
      .tx_trig_q (tx_trig_q),
      .flow_lo_q (flow_lo_q),
      .flow_hi_q (flow_hi_q)
   );

   logic [DW-1:0] rx_lvl;
   logic [DW-1:0] tx_lvl;

   flm_trigger_sel #(.DW(DW)) u_trig (
      .enh     (cfg_q[CFG_ENH_BIT]),
      .rx_code (cfg_q[7:6]),
      .tx_code (cfg_q[5:4]),
      .prog_rx (rx_trig_q),
      .prog_tx (tx_trig_q),
      .rx_lvl  (rx_lvl),
      .tx_lvl  (tx_lvl)
   );

   flm_flow_ctl #(.DW(DW)) u_flow (
      .clk   (clk),
      .rst_n (rst_n),
      .fill  (rx_fill_w),
      .lo    (flow_lo_q),
      .hi    (flow_hi_q),
      .stop  (flow_stop)
   );

   assign rx_irq = (rx_fill_w >= rx_lvl);
   assign tx_irq = (tx_fill_w <= tx_lvl);

   always_comb begin
      unique case (flm_addr_e'(reg_addr))
         A_CFG:     reg_rdata = cfg_q;
         A_RX_TRIG: reg_rdata = rx_trig_q;
         A_TX_TRIG: reg_rdata = tx_trig_q;
         A_FLOW_LO: reg_rdata = flow_lo_q;
         A_FLOW_HI: reg_rdata = flow_hi_q;
         A_RX_FILL: reg_rdata = rx_fill_w;
         A_TX_FILL: reg_rdata = tx_fill_w;
         default:   reg_rdata = DW'({flow_stop, peer_stop});
      endcase
   end

endmodule

// File: rtl/flm_checker.sv
`timescale 1ns/1ps
module flm_checker #(
   parameter int unsigned DEPTH = 128,
   parameter int unsigned DW    = 8,
   parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_inc,
   input logic          rx_dec,
   input logic          tx_inc,
   input logic          tx_dec,
   input logic          peer_stop,
   input logic [CW-1:0] rx_fill,
   input logic [CW-1:0] tx_fill,
   input logic [DW-1:0] flow_lo,
   input logic [DW-1:0] flow_hi,
   input logic          flow_stop,
   input logic [2:0]    reg_addr,
   input logic [DW-1:0] reg_rdata
);

   p_ceiling_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_fill <= CW'(DEPTH)) && (tx_fill <= CW'(DEPTH)));

   p_rx_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_inc && !rx_dec && rx_fill < CW'(DEPTH)) |=> (rx_fill == $past(rx_fill) + CW'(1)));

   p_tx_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_dec && !tx_inc && tx_fill != '0) |=> (tx_fill == $past(tx_fill) - CW'(1)));

   p_cancel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_inc && rx_dec) |=> $stable(rx_fill));

   p_fill_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 3'd5) |-> (reg_rdata == DW'(rx_fill)));

   p_flow_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (DW'(rx_fill) >= flow_hi) |=> flow_stop);

   p_flow_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((DW'(rx_fill) <= flow_lo) && (DW'(rx_fill) < flow_hi)) |=> !flow_stop);

   p_flow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((DW'(rx_fill) > flow_lo) && (DW'(rx_fill) < flow_hi)) |=> (flow_stop == $past(flow_stop)));

   p_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 3'd7) |-> (reg_rdata[1:0] == {flow_stop, peer_stop}));

endmodule

bind fifo_level_monitor flm_checker #(.DEPTH(DEPTH), .DW(DW)) u_flm_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_inc    (rx_inc),
   .rx_dec    (rx_dec),
   .tx_inc    (tx_inc),
   .tx_dec    (tx_dec),
   .peer_stop (peer_stop),
   .rx_fill   (rx_fill),
   .tx_fill   (tx_fill),
   .flow_lo   (flow_lo_q),
   .flow_hi   (flow_hi_q),
   .flow_stop (flow_stop),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata)
);

// File: tb/test_fifo_level_monitor.sv
`timescale 1ns/1ps
module test_fifo_level_monitor;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       rx_inc = 1'b0, rx_dec = 1'b0, tx_inc = 1'b0, tx_dec = 1'b0;
   logic       peer_stop = 1'b0;
   logic       rx_irq, tx_irq, flow_stop;

   always #4 clk = ~clk;

   fifo_level_monitor i_fifo_level_monitor (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_inc(rx_inc), .rx_dec(rx_dec), .tx_inc(tx_inc), .tx_dec(tx_dec),
      .peer_stop(peer_stop), .rx_irq(rx_irq), .tx_irq(tx_irq), .flow_stop(flow_stop)
   );

   integer n_chk = 0;
   integer n_fail = 0;
   bit     run = 1'b0;
   bit     done = 1'b0;

   // reference model state
   integer m_rx, m_tx, m_stop;
   integer m_reg [5];

   task automatic chk(input string tag, input integer act, input integer exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic integer leg_rx(input integer c);
      integer t [4] = '{1, 4, 8, 14};
      return t[c];
   endfunction

   function automatic integer leg_tx(input integer c);
      integer t [4] = '{0, 4, 8, 16};
      return t[c];
   endfunction

   function automatic bit m_enh();
      return m_reg[0][0];
   endfunction

   function automatic integer m_rx_lvl();
      return m_enh() ? m_reg[1] : leg_rx((m_reg[0] >> 6) & 3);
   endfunction

   function automatic integer m_tx_lvl();
      return m_enh() ? m_reg[2] : leg_tx((m_reg[0] >> 4) & 3);
   endfunction

   function automatic integer m_read(input integer a);
      if (a < 5)  return m_reg[a];
      if (a == 5) return m_rx;
      if (a == 6) return m_tx;
      return (m_stop << 1) | (peer_stop ? 1 : 0);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rx = 0; m_tx = 0; m_stop = 0;
         m_reg[0] = 0; m_reg[1] = 1; m_reg[2] = 0; m_reg[3] = 32; m_reg[4] = 96;
      end else begin
         if (m_rx >= m_reg[4])      m_stop = 1;
         else if (m_rx <= m_reg[3]) m_stop = 0;
         if (rx_inc && !rx_dec && m_rx < 128) m_rx++;
         if (rx_dec && !rx_inc && m_rx > 0)   m_rx--;
         if (tx_inc && !tx_dec && m_tx < 128) m_tx++;
         if (tx_dec && !tx_inc && m_tx > 0)   m_tx--;
         if (reg_wr && reg_addr < 5) m_reg[reg_addr] = reg_wdata;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (run && rst_n) begin
         chk(m_enh() ? "R4 rx_irq" : "R6 rx_irq", rx_irq, (m_rx >= m_rx_lvl()) ? 1 : 0);
         chk(m_enh() ? "R5 tx_irq" : "R6 tx_irq", tx_irq, (m_tx <= m_tx_lvl()) ? 1 : 0);
         chk("R8 flow_stop", flow_stop, m_stop);
         chk(reg_addr == 7 ? "R9 status" : (reg_addr >= 5 ? "R3 fill read" : "R10 reg read"),
             reg_rdata, m_read(reg_addr));
      end
   end

   task automatic step(input bit w, input integer a, input integer d,
                       input bit ri, input bit rd, input bit ti, input bit td);
      @(negedge clk); #1;
      reg_wr = w; reg_addr = 3'(a); reg_wdata = 8'(d);
      rx_inc = ri; rx_dec = rd; tx_inc = ti; tx_dec = td;
   endtask

   task automatic idle(input integer a);
      step(1'b0, a, 0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic wreg(input integer a, input integer d);
      step(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0);
      idle(a);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the ports
      chk("R1 rx_irq", rx_irq, 0);
      chk("R1 tx_irq", tx_irq, 1);
      chk("R1 flow_stop", flow_stop, 0);
      for (int a = 0; a < 7; a++) begin
         integer exp1 [7] = '{0, 1, 0, 32, 96, 0, 0};
         #1 reg_addr = 3'(a);
         #1 chk("R1 reset read", reg_rdata, exp1[a]);
      end
      run = 1'b1;

      // R2 fill to the ceiling in legacy mode with code 0
      for (int i = 0; i < 132; i++) step(1'b0, 5, 0, 1'b1, 1'b0, 1'b0, 1'b0);
      idle(5);
      @(negedge clk); chk("R2 rx ceiling", reg_rdata, 128);
      // cancel: both strobes
      for (int i = 0; i < 4; i++) step(1'b0, 5, 0, 1'b1, 1'b1, 1'b1, 1'b1);
      idle(5);
      @(negedge clk); chk("R2 rx cancel", reg_rdata, 128);
      // drain through the flow window
      for (int i = 0; i < 132; i++) step(1'b0, 7, 0, 1'b0, 1'b1, 1'b0, 1'b0);
      idle(5);
      @(negedge clk); chk("R2 rx floor", reg_rdata, 0);

      // R6 legacy code sweep, trigger registers set far away
      wreg(1, 100); wreg(2, 100);
      for (int c = 0; c < 4; c++) begin
         wreg(0, (c << 6) | (c << 4));
         for (int i = 0; i < 18; i++) step(1'b0, 6, 0, 1'b1, 1'b0, 1'b1, 1'b0);
         for (int i = 0; i < 18; i++) step(1'b0, 5, 0, 1'b0, 1'b1, 1'b0, 1'b1);
      end

      // R4 R5 R7 enhanced mode with junk in the legacy field
      wreg(1, 20); wreg(2, 10);
      wreg(0, 8'hF1);
      for (int i = 0; i < 25; i++) step(1'b0, 6, 0, 1'b1, 1'b0, 1'b1, 1'b0);
      idle(5);
      @(negedge clk);
      chk("R7 rx_irq ignores legacy field", rx_irq, 1);
      chk("R7 tx_irq ignores legacy field", tx_irq, 0);
      for (int i = 0; i < 30; i++) step(1'b0, 6, 0, 1'b0, 1'b1, 1'b0, 1'b1);

      // R8 hysteresis with lo 10, hi 40
      wreg(3, 10); wreg(4, 40);
      for (int i = 0; i < 45; i++) step(1'b0, 7, 0, 1'b1, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 20; i++) step(1'b0, 7, 0, 1'b0, 1'b1, 1'b0, 1'b0);
      idle(7);
      @(negedge clk); chk("R8 held inside window", flow_stop, 1);
      for (int i = 0; i < 20; i++) step(1'b0, 7, 0, 1'b0, 1'b1, 1'b0, 1'b0);
      idle(7);
      @(negedge clk); chk("R8 released at low", flow_stop, 0);
      for (int i = 0; i < 12; i++) step(1'b0, 7, 0, 1'b1, 1'b0, 1'b0, 1'b0);

      // R9 peer stop in the status word
      #1 peer_stop = 1'b1;
      idle(7); idle(7);
      @(negedge clk); chk("R9 peer bit", reg_rdata & 1, 1);
      #1 peer_stop = 1'b0;
      idle(7);

      // R10 writes to read-only addresses change nothing
      step(1'b1, 5, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b1, 6, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b1, 7, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int a = 0; a < 8; a++) idle(a);
      idle(0); idle(0);

      run = 1'b0;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule